// File: doc/BRIEF.md
# Three-Phase Inverter Fault Supervisor

This block watches over the gate commands of a three-phase inverter and decides when the power stage must be switched off. It takes one over-current comparator flag, one under-voltage flag for the shared low-side supply, one under-voltage flag for each high-side supply, and the six active-low PWM commands (three high-side, three low-side). It produces a global shutdown that forces all six gate outputs off, a high-side disable for each phase, and an open-drain enable for an active-low fault line. All timing is counted in clock cycles and set by parameters. The block has no data stream, so every pin is a plain level signal with no handshake and no back-pressure.

A trip that arrives while the commands are quiet sets a latched fault. A trip that falls inside the blanking window after any command edge is ignored, because switching noise lands there. The latched fault holds until the clearing commands have stayed inactive for a full qualification time. One parameter selects which commands take part in clearing: the low-side commands alone, or all six. A low-side under-voltage shuts the stage down only for as long as the flag is present. A high-side under-voltage disables the high-side output of its own phase and nothing else. After reset the stage is held off and the fault line stays asserted until the first clearing sequence completes.

Top module: `inv_guard_top`

## Requirements
- R1: A trip flag sampled high outside the blanking window sets the latched fault. `shut_o` is high at the second rising edge after the edge that sampled the trip.
- R2: When any of the six commands differs from its value at the previous edge, the trip flag is ignored at that edge and at the next BLANK_CYC-1 edges.
- R3: Once set, the latched fault keeps `shut_o` high after the trip flag falls, for as long as the clearing condition has not been met.
- R4: The latched fault clears after CLR_CYC consecutive edges at which every participating command is high (inactive). An edge with any participating command low restarts the count.
- R5: With BOTH_CLR=0 only `lin_n_i` takes part in clearing, and `hin_n_i` activity does not delay the clear. With BOTH_CLR=1, `hin_n_i` must also stay high.
- R6: If the trip flag is still sampled high at the edge where the count expires, the fault stays latched and the count starts again.
- R7: `ls_uv_i` sampled high sets `shut_o` one edge later. The effect is not latched, and `shut_o` falls one edge after the flag is sampled low if no trip fault is pending.
- R8: `hs_dis_o[p]` follows `hs_uv_i[p]` one edge later and leaves `shut_o` and the other phases untouched.
- R9: During reset `shut_o` and `flt_oe_o` are 1 and `hs_dis_o` is all ones. The fault stays latched after reset until R4 completes once.
- R10: `flt_oe_o` (1 = pull the fault line low) equals `shut_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_i | input | 1 | Over-current comparator flag, 1 = over-current |
| ls_uv_i | input | 1 | Low-side supply under-voltage, debounced, 1 = low |
| hs_uv_i | input | NPH | Per-phase high-side supply under-voltage, 1 = low |
| hin_n_i | input | NPH | High-side PWM commands, active low |
| lin_n_i | input | NPH | Low-side PWM commands, active low |
| shut_o | output | 1 | Global shutdown, 1 = all six gates off |
| hs_dis_o | output | NPH | Per-phase high-side disable |
| flt_oe_o | output | 1 | Fault line pull-down enable, 1 = fault asserted |

## Verification
Two pairs of events can land in the same cycle. A trip can arrive on the very sample that carries a command edge, and the trip flag can still be high on the edge where the clear count expires. The bench provokes the first pair by dropping a low-side command together with a trip pulse held for exactly the blanking length. It provokes the second by keeping a trip high while toggling a high-side command every cycle, so the trip stays blanked while the low-side-only variant keeps counting. A cycle-level behavioural model judges both pairs: the fault must not rise in the first case, and in the second it must survive each expiry until the trip is released.

// File: rtl/inv_guard_pkg.sv
package inv_guard_pkg;
  typedef enum logic {
    GRD_RUN     = 1'b0,
    GRD_LATCHED = 1'b1
  } grd_state_e;

  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/inv_guard_blank.sv
module inv_guard_blank
  import inv_guard_pkg::*;
#(
  parameter int unsigned NPH       = 3,
  parameter int unsigned BLANK_CYC = 20,
  localparam int unsigned BW       = cnt_bits(BLANK_CYC + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trip_i,
  input  logic [NPH-1:0] hin_n_i,
  input  logic [NPH-1:0] lin_n_i,
  output logic           trip_q_o,
  output logic           trip_ok_o,
  output logic [BW-1:0]  blank_cnt_o
);
  localparam int unsigned NCMD = 2 * NPH;
  localparam logic [BW-1:0] BLANK_LOAD = BW'(BLANK_CYC);

  logic [NCMD-1:0] cmd_now;
  logic [NCMD-1:0] cmd_q;
  logic            sw_edge;
  logic [BW-1:0]   cnt_q;
  logic            trip_q;

  assign cmd_now = {hin_n_i, lin_n_i};
  assign sw_edge = |(cmd_now ^ cmd_q);

  // switching-edge detector and blanking down-counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '1;
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_now;
      trip_q <= trip_i;
      if (sw_edge) begin
        cnt_q <= BLANK_LOAD;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign trip_q_o    = trip_q;
  assign trip_ok_o   = trip_q && (cnt_q == '0);
  assign blank_cnt_o = cnt_q;
endmodule

// File: rtl/inv_guard_clrtmr.sv
module inv_guard_clrtmr
  import inv_guard_pkg::*;
#(
  parameter int unsigned NPH      = 3,
  parameter int unsigned CLR_CYC  = 100000,
  parameter bit          BOTH_CLR = 1'b0,
  localparam int unsigned CW      = cnt_bits(CLR_CYC)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPH-1:0] hin_n_i,
  input  logic [NPH-1:0] lin_n_i,
  input  logic           trip_ok_i,
  input  logic           trip_q_i,
  output logic           fault_o,
  output logic           cond_o,
  output logic [CW-1:0]  cnt_o
);
  localparam logic [CW-1:0]  LAST  = CW'(CLR_CYC - 1);
  localparam logic [NPH-1:0] HMASK = BOTH_CLR ? '0 : '1;

  grd_state_e    st_q;
  logic [CW-1:0] cnt_q;
  logic          cond;

  // high-side commands count only in the both-sides variant
  assign cond = (&lin_n_i) & (&(hin_n_i | HMASK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= GRD_LATCHED;
      cnt_q <= '0;
    end else if (trip_ok_i) begin
      st_q  <= GRD_LATCHED;
      cnt_q <= '0;
    end else if (st_q == GRD_LATCHED) begin
      if (!cond) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        cnt_q <= '0;
        if (!trip_q_i) st_q <= GRD_RUN;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign fault_o = (st_q == GRD_LATCHED);
  assign cond_o  = cond;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/inv_guard_uvsync.sv
module inv_guard_uvsync #(
  parameter int unsigned NPH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ls_uv_i,
  input  logic [NPH-1:0] hs_uv_i,
  output logic           ls_uv_q_o,
  output logic [NPH-1:0] hs_dis_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ls_uv_q_o <= 1'b1;
    else        ls_uv_q_o <= ls_uv_i;
  end

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    logic dis_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dis_q <= 1'b1;
      else        dis_q <= hs_uv_i[p];
    end
    assign hs_dis_o[p] = dis_q;
  end
endmodule

// File: rtl/inv_guard_top.sv
module inv_guard_top
  import inv_guard_pkg::*;
#(
  parameter int unsigned NPH       = 3,
  parameter int unsigned BLANK_CYC = 20,
  parameter int unsigned CLR_CYC   = 100000,
  parameter bit          BOTH_CLR  = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trip_i,
  input  logic           ls_uv_i,
  input  logic [NPH-1:0] hs_uv_i,
  input  logic [NPH-1:0] hin_n_i,
  input  logic [NPH-1:0] lin_n_i,
  output logic           shut_o,
  output logic [NPH-1:0] hs_dis_o,
  output logic           flt_oe_o
);
  localparam int unsigned BW = cnt_bits(BLANK_CYC + 1);
  localparam int unsigned CW = cnt_bits(CLR_CYC);

  logic          trip_q_w;
  logic          trip_ok_w;
  logic [BW-1:0] blank_cnt_w;
  logic          fault_w;
  logic          cond_w;
  logic [CW-1:0] clr_cnt_w;
  logic          ls_uv_q_w;

  inv_guard_blank #(.NPH(NPH), .BLANK_CYC(BLANK_CYC)) u_blank (
    .clk(clk), .rst_n(rst_n), .trip_i(trip_i),
    .hin_n_i(hin_n_i), .lin_n_i(lin_n_i),
    .trip_q_o(trip_q_w), .trip_ok_o(trip_ok_w), .blank_cnt_o(blank_cnt_w)
  );

  inv_guard_clrtmr #(.NPH(NPH), .CLR_CYC(CLR_CYC), .BOTH_CLR(BOTH_CLR)) u_clr (
    .clk(clk), .rst_n(rst_n),
    .hin_n_i(hin_n_i), .lin_n_i(lin_n_i),
    .trip_ok_i(trip_ok_w), .trip_q_i(trip_q_w),
    .fault_o(fault_w), .cond_o(cond_w), .cnt_o(clr_cnt_w)
  );

  inv_guard_uvsync #(.NPH(NPH)) u_uv (
    .clk(clk), .rst_n(rst_n), .ls_uv_i(ls_uv_i), .hs_uv_i(hs_uv_i),
    .ls_uv_q_o(ls_uv_q_w), .hs_dis_o(hs_dis_o)
  );

  assign shut_o   = fault_w | ls_uv_q_w;
  assign flt_oe_o = fault_w | ls_uv_q_w;
endmodule

// File: rtl/inv_guard_chk.sv
module inv_guard_chk
  import inv_guard_pkg::*;
#(
  parameter int unsigned NPH       = 3,
  parameter int unsigned BLANK_CYC = 20,
  parameter int unsigned CLR_CYC   = 100000,
  localparam int unsigned BW       = cnt_bits(BLANK_CYC + 1),
  localparam int unsigned CW       = cnt_bits(CLR_CYC)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ls_uv_i,
  input logic [NPH-1:0] hs_uv_i,
  input logic           trip_q,
  input logic [BW-1:0]  blank_cnt,
  input logic           fault_q,
  input logic           cond,
  input logic [CW-1:0]  clr_cnt,
  input logic           shut_o,
  input logic [NPH-1:0] hs_dis_o
);
  localparam logic [CW-1:0] LAST = CW'(CLR_CYC - 1);

  a_r1_trip_shuts: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_q && blank_cnt == '0) |=> (shut_o && fault_q));

  a_r2_blank_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_q && blank_cnt != '0) |=> !fault_q);

  a_r3_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && clr_cnt != LAST) |=> fault_q);

  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !cond) |=> (clr_cnt == '0));

  a_r6_trip_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && trip_q) |=> fault_q);

  a_r7_uv_shuts: assert property (@(posedge clk) disable iff (!rst_n)
    ls_uv_i |=> shut_o);

  a_r8_hs_follow: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (hs_dis_o == $past(hs_uv_i)));
endmodule

bind inv_guard_top inv_guard_chk #(
  .NPH(NPH), .BLANK_CYC(BLANK_CYC), .CLR_CYC(CLR_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ls_uv_i(ls_uv_i), .hs_uv_i(hs_uv_i),
  .trip_q(trip_q_w), .blank_cnt(blank_cnt_w), .fault_q(fault_w),
  .cond(cond_w), .clr_cnt(clr_cnt_w), .shut_o(shut_o), .hs_dis_o(hs_dis_o)
);

// File: tb/inv_guard_top_tb_top.sv
module inv_guard_top_tb_top;
  localparam int CLK_PER = 10;
  localparam int BLK     = 4;
  localparam int CLR     = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trip = 1'b0;
  logic       ls_uv = 1'b0;
  logic [2:0] hs_uv = 3'b000;
  logic [2:0] hin = 3'b111;
  logic [2:0] lin = 3'b111;

  logic       shut_a, flt_a, shut_b, flt_b;
  logic [2:0] hsd_a, hsd_b;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R9";

  always #(CLK_PER/2) clk = ~clk;

  inv_guard_top #(.NPH(3), .BLANK_CYC(BLK), .CLR_CYC(CLR), .BOTH_CLR(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .trip_i(trip), .ls_uv_i(ls_uv), .hs_uv_i(hs_uv),
    .hin_n_i(hin), .lin_n_i(lin), .shut_o(shut_a), .hs_dis_o(hsd_a), .flt_oe_o(flt_a)
  );

  inv_guard_top #(.NPH(3), .BLANK_CYC(BLK), .CLR_CYC(CLR), .BOTH_CLR(1'b1)) dut_b (
    .clk(clk), .rst_n(rst_n), .trip_i(trip), .ls_uv_i(ls_uv), .hs_uv_i(hs_uv),
    .hin_n_i(hin), .lin_n_i(lin), .shut_o(shut_b), .hs_dis_o(hsd_b), .flt_oe_o(flt_b)
  );

  task automatic chk(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference: sample index, last command change, per-variant fault and count
  int       m_n;
  int       m_lastsw;
  bit       m_trip_prev;
  bit [5:0] m_prev_cmd;
  bit       m_f[2];
  int       m_cnt[2];
  bit       m_uv;
  bit [2:0] m_hsd;
  bit       m_valid = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_n = 0; m_lastsw = -1000; m_trip_prev = 1'b0; m_prev_cmd = '1;
      m_f[0] = 1'b1; m_f[1] = 1'b1; m_cnt[0] = 0; m_cnt[1] = 0;
      m_uv = 1'b1; m_hsd = 3'b111; m_valid = 1'b1;
    end else begin
      bit       hit;
      bit       cnd[2];
      bit [5:0] cmd;
      cmd    = {hin, lin};
      hit    = m_trip_prev && (((m_n - 1) - m_lastsw) >= BLK);
      cnd[0] = (lin == 3'b111);
      cnd[1] = (lin == 3'b111) && (hin == 3'b111);
      for (int v = 0; v < 2; v++) begin
        if (hit) begin
          m_f[v] = 1'b1; m_cnt[v] = 0;
        end else if (m_f[v]) begin
          if (!cnd[v]) m_cnt[v] = 0;
          else begin
            m_cnt[v] = m_cnt[v] + 1;
            if (m_cnt[v] >= CLR) begin
              m_cnt[v] = 0;
              if (!m_trip_prev) m_f[v] = 1'b0;
            end
          end
        end
      end
      if (cmd != m_prev_cmd) m_lastsw = m_n;
      m_prev_cmd = cmd; m_trip_prev = trip; m_uv = ls_uv; m_hsd = hs_uv;
      m_n++;
    end
  end

  always @(negedge clk) begin
    if (m_valid && !done) begin
      chk(cur_req, "shut variant0", 4'(shut_a), 4'(m_f[0] | m_uv));
      chk(cur_req, "shut variant1", 4'(shut_b), 4'(m_f[1] | m_uv));
      chk("R10", "fault line variant0", 4'(flt_a), 4'(m_f[0] | m_uv));
      chk("R10", "fault line variant1", 4'(flt_b), 4'(m_f[1] | m_uv));
      chk("R8", "hs disable variant0", 4'(hsd_a), 4'(m_hsd));
      chk("R8", "hs disable variant1", 4'(hsd_b), 4'(m_hsd));
    end
  end

  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    chk("R9", "reset shut", 4'(shut_a), 4'd1);
    chk("R9", "reset fault line", 4'(flt_b), 4'd1);
    chk("R9", "reset hs disable", 4'(hsd_a), 4'h7);
    rst_n = 1'b1;
    cyc(19);
    chk("R9", "still held before first clear", 4'(shut_a), 4'd1);
    cyc(1);
    chk("R4", "first clear done", 4'({shut_a, shut_b}), 4'd0);

    cur_req = "R2";
    lin[0] = 1'b0; trip = 1'b1;
    cyc(BLK);
    trip = 1'b0;
    cyc(2);
    lin[0] = 1'b1;
    cyc(4);
    chk("R2", "blanked trip ignored", 4'({shut_a, shut_b}), 4'd0);

    cur_req = "R1";
    lin[1] = 1'b0;
    cyc(BLK + 2);
    trip = 1'b1;
    cyc(1);
    chk("R1", "one edge after trip", 4'(shut_a), 4'd0);
    trip = 1'b0;
    cyc(1);
    chk("R1", "two edges after trip", 4'({shut_a, shut_b}), 4'h3);

    cur_req = "R3";
    cyc(30);
    chk("R3", "fault held", 4'({flt_a, flt_b}), 4'h3);

    cur_req = "R4";
    lin = 3'b111;
    cyc(10);
    lin[2] = 1'b0;
    cyc(1);
    lin[2] = 1'b1;
    cyc(19);
    chk("R4", "count restarted", 4'(shut_a), 4'd1);
    cyc(1);
    chk("R4", "cleared after full count", 4'({shut_a, shut_b}), 4'd0);

    cur_req = "R5";
    trip = 1'b1;
    cyc(1);
    trip = 1'b0;
    cyc(3);
    for (int i = 0; i < 26; i++) begin
      hin[0] = ~hin[0];
      cyc(1);
    end
    chk("R5", "low-side-only variant clears", 4'(shut_a), 4'd0);
    chk("R5", "both-sides variant held", 4'(shut_b), 4'd1);
    cyc(22);
    chk("R5", "both-sides variant clears", 4'(shut_b), 4'd0);

    cur_req = "R6";
    trip = 1'b1;
    cyc(3);
    for (int i = 0; i < 40; i++) begin
      hin[1] = ~hin[1];
      cyc(1);
    end
    chk("R6", "trip at expiry keeps fault", 4'(shut_a), 4'd1);
    trip = 1'b0;
    for (int i = 0; i < 26; i++) begin
      hin[1] = ~hin[1];
      cyc(1);
    end
    chk("R6", "clears once trip gone", 4'(shut_a), 4'd0);
    hin = 3'b111;
    cyc(25);

    cur_req = "R7";
    ls_uv = 1'b1;
    cyc(1);
    chk("R7", "uv shuts", 4'({shut_a, flt_b}), 4'h3);
    cyc(2);
    ls_uv = 1'b0;
    cyc(1);
    chk("R7", "uv not latched", 4'({shut_a, shut_b}), 4'd0);

    cur_req = "R8";
    hs_uv = 3'b010;
    cyc(1);
    chk("R8", "phase 1 disabled", 4'(hsd_a), 4'h2);
    chk("R8", "shutdown untouched", 4'(shut_a), 4'd0);
    hs_uv = 3'b000;
    cyc(2);

    cur_req = "R1";
    lin[2] = 1'b0; trip = 1'b1; ls_uv = 1'b1;
    cyc(1);
    trip = 1'b0; ls_uv = 1'b0; lin[2] = 1'b1;
    cyc(4);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule